// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block decides when an analog-to-digital converter begins a conversion sequence. Software writes a start command. The block then either launches a sequence at once or waits for an external trigger, depending on four mode bits: trigger enable, edge/level select, trigger polarity and scan. The converter datapath reports the end of each sequence with a one-cycle completion pulse, and the block decides whether another sequence follows.

The external trigger is asynchronous. It passes through a flop synchronizer before any decision is made. In edge modes, a qualifying edge that arrives while a sequence is running is lost, and a sticky overrun flag records the loss. In level modes, sequences follow one another without a gap for as long as the trigger stays at its active level, and trigger activity never counts as an overrun.

Top module: `adc_trig_seq`

## Requirements
- R1: While reset is asserted and after it is released, trigOverrun reads 0. With no start write, seqStart stays 0.
- R2: With trigEnable=0 and scanMode=0, a startWr pulse drives seqStart high in the same cycle. After the following seqDone, no further seqStart occurs. levelMode and trigPolarity have no effect in this mode.
- R3: With trigEnable=0 and scanMode=1, seqStart is high in the startWr cycle and again in every cycle in which seqDone arrives. extTrig has no effect.
- R4: With trigEnable=1 and levelMode=0, a qualifying edge starts one sequence. trigPolarity=1 selects rising edges and trigPolarity=0 selects falling edges. An edge is detected when the output of the two-flop synchronizer differs from its value one cycle earlier. seqStart rises in that cycle if the block is armed. scanMode is ignored.
- R5: With trigEnable=1 and levelMode=1, an armed block asserts seqStart in any cycle in which the synchronized trigger equals trigPolarity. trigPolarity=1 means active high and trigPolarity=0 means active low.
- R6: With trigEnable=1, the startWr cycle itself never carries seqStart. It only arms the block.
- R7: In edge mode, a qualifying edge during a sequence sets trigOverrun on the next clock, provided the edge does not fall in the seqDone cycle or a startWr cycle. Such an edge starts no extra sequence. An edge that falls in the seqDone cycle starts the next sequence in that same cycle.
- R8: In level mode, trigOverrun is never set, however the trigger toggles during a sequence.
- R9: In level mode, if the synchronized trigger is active in the seqDone cycle, seqStart is high in that same cycle, with no idle gap.
- R10: trigOverrun stays 1 until an ovrClr pulse arrives. When a clear and a new overrun occur in the same cycle, the flag ends up set.
- R11: A startWr during a running sequence aborts it. Untriggered modes restart at once with seqStart. Triggered modes return to the armed state under the current mode bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| levelMode | input | 1 | 1 = level sensitive, 0 = edge sensitive |
| trigPolarity | input | 1 | 1 = rising / high, 0 = falling / low |
| trigEnable | input | 1 | 1 = sequences wait on the external trigger |
| scanMode | input | 1 | Untriggered: 1 = continuous, 0 = single |
| extTrig | input | 1 | Asynchronous external trigger |
| startWr | input | 1 | One-cycle pulse from the control-register write |
| seqDone | input | 1 | One-cycle completion pulse from the converter |
| ovrClr | input | 1 | Clears the overrun flag |
| seqStart | output | 1 | One-cycle pulse that launches a conversion sequence |
| trigOverrun | output | 1 | Sticky edge-mode trigger overrun flag |

## Verification
The hardest cases to reach are the coincidences: an ovrClr in the same cycle as a fresh overrun edge, and a qualifying edge that lands exactly in the seqDone cycle. Both depend on the two-cycle synchronizer delay lining up with the converter's completion. The bench's converter model picks a random sequence length for every launch, and the trigger toggles at a random rate. Directed phases hold ovrClr high while edges arrive faster than the sequences finish, so these cycles occur many times. A cycle-by-cycle reference model judges each one.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_BUSY  = 2'd2
  } seqState_e;

  typedef enum logic [1:0] {
    MODE_ONCE  = 2'd0,
    MODE_CONT  = 2'd1,
    MODE_EDGE  = 2'd2,
    MODE_LEVEL = 2'd3
  } trigMode_e;

  // Strobes from control to the trigger datapath
  typedef struct packed {
    logic ovrWindow;   // an edge seen now would be lost
    logic activeHigh;  // qualifying polarity
  } ctrlStrobes_t;

endpackage

// File: rtl/adc_trig_dp.sv
module adc_trig_dp
  import adc_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         extTrig,
  input  logic         ovrClr,
  input  ctrlStrobes_t strb,
  output logic         edgeHit,
  output logic         levelActive,
  output logic         trigOverrun
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic trigSync;
  logic trigPrev;
  logic riseSeen;
  logic fallSeen;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= extTrig;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], extTrig};
      end
    end
  endgenerate

  assign trigSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trigPrev <= 1'b0;
    else       trigPrev <= trigSync;
  end

  assign riseSeen    = trigSync & ~trigPrev;
  assign fallSeen    = ~trigSync & trigPrev;
  assign edgeHit     = strb.activeHigh ? riseSeen : fallSeen;
  assign levelActive = (trigSync == strb.activeHigh);

  // Set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          trigOverrun <= 1'b0;
    else if (strb.ovrWindow && edgeHit) trigOverrun <= 1'b1;
    else if (ovrClr)                    trigOverrun <= 1'b0;
  end

endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         levelMode,
  input  logic         trigPolarity,
  input  logic         trigEnable,
  input  logic         scanMode,
  input  logic         startWr,
  input  logic         seqDone,
  input  logic         edgeHit,
  input  logic         levelActive,
  output logic         seqStart,
  output ctrlStrobes_t strb
);

  seqState_e state, stateNext;
  trigMode_e mode;
  logic      trigHit;

  always_comb begin
    if (!trigEnable) mode = scanMode ? MODE_CONT : MODE_ONCE;
    else             mode = levelMode ? MODE_LEVEL : MODE_EDGE;
  end

  assign trigHit = (mode == MODE_LEVEL) ? levelActive : edgeHit;

  always_comb begin
    stateNext      = state;
    seqStart       = 1'b0;
    strb.ovrWindow = 1'b0;
    strb.activeHigh = trigPolarity;
    if (startWr) begin
      if (!trigEnable) begin
        seqStart  = 1'b1;
        stateNext = ST_BUSY;
      end else begin
        stateNext = ST_ARMED;
      end
    end else begin
      unique case (state)
        ST_ARMED: begin
          if (trigEnable && trigHit) begin
            seqStart  = 1'b1;
            stateNext = ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (seqDone) begin
            unique case (mode)
              MODE_ONCE: stateNext = ST_IDLE;
              MODE_CONT: seqStart  = 1'b1;
              default: begin
                if (trigHit) seqStart  = 1'b1;
                else         stateNext = ST_ARMED;
              end
            endcase
          end else if (mode == MODE_EDGE) begin
            strb.ovrWindow = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adc_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic levelMode,
  input  logic trigPolarity,
  input  logic trigEnable,
  input  logic scanMode,
  input  logic extTrig,
  input  logic startWr,
  input  logic seqDone,
  input  logic ovrClr,
  output logic seqStart,
  output logic trigOverrun
);

  ctrlStrobes_t ctlStrb;
  logic edgeHit;
  logic levelActive;

  adc_trig_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .levelMode(levelMode), .trigPolarity(trigPolarity),
    .trigEnable(trigEnable), .scanMode(scanMode),
    .startWr(startWr), .seqDone(seqDone),
    .edgeHit(edgeHit), .levelActive(levelActive),
    .seqStart(seqStart), .strb(ctlStrb)
  );

  adc_trig_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN),
    .extTrig(extTrig), .ovrClr(ovrClr), .strb(ctlStrb),
    .edgeHit(edgeHit), .levelActive(levelActive),
    .trigOverrun(trigOverrun)
  );

endmodule

// File: rtl/adc_trig_seq_chk.sv
module adc_trig_seq_chk (
  input logic clk,
  input logic rstN,
  input logic trigEnable,
  input logic levelMode,
  input logic startWr,
  input logic seqDone,
  input logic ovrClr,
  input logic seqStart,
  input logic trigOverrun,
  input logic ovrWindow
);

  always @(posedge clk) begin
    if (!rstN) begin
      a_r1_reset_clear: assert (!trigOverrun);
    end
  end

  a_r2_untrig_immediate: assert property (@(posedge clk) disable iff (!rstN)
    (startWr && !trigEnable) |-> seqStart);

  a_r6_arm_only: assert property (@(posedge clk) disable iff (!rstN)
    (startWr && trigEnable) |-> !seqStart);

  a_r7_no_extra_seq: assert property (@(posedge clk) disable iff (!rstN)
    (ovrWindow && !seqDone) |-> !seqStart);

  a_r8_level_no_ovr: assert property (@(posedge clk) disable iff (!rstN)
    (trigEnable && levelMode && !trigOverrun) |=> !trigOverrun);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (trigOverrun && !ovrClr) |=> trigOverrun);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    (trigOverrun && ovrClr && !ovrWindow) |=> !trigOverrun);

endmodule

bind adc_trig_seq adc_trig_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .trigEnable(trigEnable), .levelMode(levelMode),
  .startWr(startWr), .seqDone(seqDone), .ovrClr(ovrClr),
  .seqStart(seqStart), .trigOverrun(trigOverrun),
  .ovrWindow(ctlStrb.ovrWindow)
);

// File: tb/adc_trig_seq_test.sv
module adc_trig_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic levelMode = 0, trigPolarity = 0, trigEnable = 0, scanMode = 0;
  logic extTrig = 0, startWr = 0, seqDone = 0, ovrClr = 0;
  logic seqStart, trigOverrun;

  adc_trig_seq uut (
    .clk(clk), .rstN(rstN), .levelMode(levelMode), .trigPolarity(trigPolarity),
    .trigEnable(trigEnable), .scanMode(scanMode), .extTrig(extTrig),
    .startWr(startWr), .seqDone(seqDone), .ovrClr(ovrClr),
    .seqStart(seqStart), .trigOverrun(trigOverrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cycles = 0, startsSeen = 0;
  bit finished = 0;
  string curTag = "R1";

  // staged inputs, applied at the next falling edge
  logic nLev = 0, nPol = 0, nEn = 0, nScan = 0, nExt = 0, nStart = 0, nClr = 0;
  int seqLenMin = 2, seqLenMax = 6;
  int busyCnt = 0;

  // reference model state
  logic [1:0] mSync = 2'b00;
  logic mPrev = 0, mOvr = 0;
  int mState = 0; // 0 idle, 1 armed, 2 busy

  task automatic check(input bit ok, input string tag, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cycles);
    end
  endtask

  function automatic bit modelHit(input logic sync, input logic prev, input logic pol, input logic lev);
    if (lev) return (sync == pol);
    return pol ? (sync & ~prev) : (~sync & prev);
  endfunction

  task automatic step();
    logic sync, hit, expStart, setOvr;
    int ns;
    @(negedge clk);
    levelMode = nLev; trigPolarity = nPol; trigEnable = nEn; scanMode = nScan;
    extTrig = nExt; startWr = nStart; ovrClr = nClr;
    seqDone = (busyCnt == 1);
    #1;
    sync = mSync[1];
    hit = modelHit(sync, mPrev, trigPolarity, levelMode);
    expStart = 0; setOvr = 0; ns = mState;
    if (startWr) begin
      if (!trigEnable) begin expStart = 1; ns = 2; end
      else ns = 1;
    end else if (mState == 1) begin
      if (trigEnable && hit) begin expStart = 1; ns = 2; end
    end else if (mState == 2) begin
      if (seqDone) begin
        if (!trigEnable && !scanMode) ns = 0;
        else if (!trigEnable) expStart = 1;
        else if (hit) expStart = 1;
        else ns = 1;
      end else if (trigEnable && !levelMode && hit) setOvr = 1;
    end
    check(seqStart === expStart, curTag, int'(seqStart), int'(expStart), "seqStart");
    check(trigOverrun === mOvr, curTag, int'(trigOverrun), int'(mOvr), "trigOverrun");
    if (seqStart === 1'b1) startsSeen++;
    mOvr = setOvr | (mOvr & ~ovrClr);
    mPrev = sync;
    mSync = {mSync[0], extTrig};
    mState = ns;
    if (startWr) busyCnt = 0;
    if (expStart) busyCnt = seqLenMin + int'($urandom_range(seqLenMax - seqLenMin));
    else if (busyCnt > 0) busyCnt--;
    nStart = 0; nClr = 0;
  endtask

  task automatic setMode(input logic en, input logic lev, input logic pol, input logic scan);
    nEn = en; nLev = lev; nPol = pol; nScan = scan; nStart = 1;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  function automatic void finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      finish();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check(trigOverrun === 1'b0, "R1", int'(trigOverrun), 0, "overrun in reset");
    @(negedge clk); rstN = 1;
    curTag = "R1";
    run(5);
    check(startsSeen == 0, "R1", startsSeen, 0, "starts without write");

    // R2: single sequence, level/polarity set but ignored
    curTag = "R2"; startsSeen = 0;
    setMode(0, 1, 1, 0); nExt = 1;
    run(20);
    check(startsSeen == 1, "R2", startsSeen, 1, "single sequence count");

    // R3: continuous, trigger toggling
    curTag = "R3"; startsSeen = 0;
    setMode(0, 0, 1, 1);
    for (int i = 0; i < 40; i++) begin nExt = $urandom_range(1); step(); end
    check(startsSeen >= 6, "R3", startsSeen, 6, "continuous starts (min)");

    // R6 + R4: rising edge, arm only
    curTag = "R6"; startsSeen = 0;
    nExt = 0; setMode(1, 0, 1, 1); step();
    curTag = "R4"; run(5);
    check(startsSeen == 0, "R6", startsSeen, 0, "armed without trigger");
    nExt = 1; run(10); nExt = 0; run(10);
    check(startsSeen == 1, "R4", startsSeen, 1, "one start per rising edge");

    // R4: falling edge
    startsSeen = 0; setMode(1, 0, 0, 0); step();
    nExt = 1; run(6); nExt = 0; run(10);
    check(startsSeen == 1, "R4", startsSeen, 1, "one start per falling edge");

    // R7 + R10: fast edges over long sequences, then clear with overlaps
    curTag = "R7"; seqLenMin = 10; seqLenMax = 14;
    nExt = 0; setMode(1, 0, 1, 0); step();
    for (int i = 0; i < 12; i++) begin nExt = ~nExt; step(); step(); end
    check(trigOverrun === 1'b1, "R7", int'(trigOverrun), 1, "overrun after extra edges");
    curTag = "R10"; run(8);
    check(trigOverrun === 1'b1, "R10", int'(trigOverrun), 1, "flag sticky");
    for (int i = 0; i < 40; i++) begin nClr = 1; nExt = $urandom_range(1); step(); end
    nClr = 1; step(); nExt = 0; nClr = 1; run(1);
    seqLenMin = 2; seqLenMax = 6;

    // R5 + R9 + R8: active-high level held, toggling mid-sequence
    curTag = "R9"; startsSeen = 0; nClr = 1; step();
    nExt = 0; setMode(1, 1, 1, 0); step();
    run(4);
    check(startsSeen == 0, "R5", startsSeen, 0, "inactive level no start");
    nExt = 1; run(40);
    check(startsSeen >= 7, "R9", startsSeen, 7, "chained level starts (min)");
    curTag = "R8";
    for (int i = 0; i < 40; i++) begin nExt = $urandom_range(1); step(); end
    check(trigOverrun === 1'b0, "R8", int'(trigOverrun), 0, "no overrun in level mode");

    // R5: active-low
    curTag = "R5"; startsSeen = 0;
    nExt = 1; setMode(1, 1, 0, 1); step(); run(5);
    check(startsSeen == 0, "R5", startsSeen, 0, "high level with active-low");
    nExt = 0; run(8);
    check(startsSeen >= 1, "R5", startsSeen, 1, "low level starts");

    // R11: abort in continuous and in edge mode
    curTag = "R11"; seqLenMin = 8; seqLenMax = 8;
    nExt = 0; setMode(0, 0, 0, 1); step(); run(3);
    setMode(0, 0, 0, 1); step(); run(3);
    setMode(1, 0, 1, 0); step(); run(6);
    seqLenMin = 2; seqLenMax = 6;

    // random mix
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(39) == 0) begin
        setMode($urandom_range(1), $urandom_range(1), $urandom_range(1), $urandom_range(1));
      end
      if (nEn && nLev) curTag = "R8";
      else if (nEn) curTag = "R7";
      else curTag = nScan ? "R3" : "R2";
      if ($urandom_range(2) == 0) nExt = $urandom_range(1);
      if ($urandom_range(14) == 0) nClr = 1;
      step();
    end
    finish();
  end
endmodule